// File: doc/BRIEF.md
# Dual-Channel Serial Result Shifter

This block sends the two 16-bit results of a simultaneous two-channel conversion over one serial data line as a single 32-bit frame, most significant bit first. It drives its own bit clock and a framing strobe to the host, so the host needs only a clock input, a data input and a frame-valid input. Which channel leads the frame is chosen per frame by a select input. Both the bit clock and the strobe can be flipped in polarity.

Two readout timings are supported. In read-after-convert timing, the frame starts as soon as the conversion finishes. The busy output then covers both the conversion and the whole transfer, and a divider select can slow the bit clock for slow hosts. In read-during-convert timing, the pair from the previous conversion is shifted out while the next conversion runs, always at the fastest bit clock. Busy then covers only the conversion.

Top module: `dual_result_shifter`

## Requirements
- R1: A frame is 32 bits, MSB first, one bit per bit-clock pulse, 32 pulses in all. With no inversion the clock idles low, each bit is presented while the clock is low, and data changes only just after a falling edge, so it never changes while the clock is high.
- R2: With `a_first_i` high at frame load the frame is {A[15:0], B[15:0]}. With it low the frame is {B[15:0], A[15:0]}.
- R3: With no inversion the strobe is high while the bits of a channel are presented. After the first channel's LSB it drops for one half-period, during which the clock stays low and the data line already shows the second channel's MSB. After the final LSB it falls and the block idles: clock low, strobe low, data 0.
- R4: `sclk_inv_i` high inverts the bit-clock output and `sync_inv_i` high inverts the strobe output, including their idle levels.
- R5: In read-after-convert timing the clock half-period is 2^`div_sel_i` system clocks (periods 2, 4, 8 and 16). In read-during-convert timing it is 1 clock, whatever `div_sel_i` is. A whole frame lasts 65 half-periods.
- R6: In read-after-convert timing (`rd_during_i` = 0), the frame loads on the clock edge that takes `conv_done_i`. `busy_o` rises the cycle after an accepted start and stays high until the frame ends.
- R7: In read-during-convert timing (`rd_during_i` = 1), an accepted start loads the pair captured by the most recent accepted done. `busy_o` equals the converting state: high from the cycle after an accepted start, low from the cycle after an accepted done.
- R8: A start pulse while `busy_o` is high is ignored, and so is a done pulse while no conversion runs. Neither restarts a frame, changes `busy_o`, or changes the held pair.
- R9: In read-during-convert timing, a start while no pair has been captured since reset, or while a frame is still shifting, begins the conversion but does not load or restart a frame.
- R10: After reset the block is idle: `busy_o` 0, `sdo_o` 0, and the clock and strobe at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_during_i | input | 1 | 0: read after convert, 1: read during next convert |
| div_sel_i | input | 2 | Bit-clock divider select (read-after-convert only) |
| a_first_i | input | 1 | 1: channel A leads the frame, 0: channel B leads |
| sclk_inv_i | input | 1 | Invert bit-clock output |
| sync_inv_i | input | 1 | Invert strobe output |
| conv_start_i | input | 1 | One-cycle pulse: conversion begins |
| conv_done_i | input | 1 | One-cycle pulse: both channels converted, results valid |
| res_a_i | input | 16 | Channel A result, valid with conv_done_i |
| res_b_i | input | 16 | Channel B result, valid with conv_done_i |
| sclk_o | output | 1 | Bit clock to host |
| sync_o | output | 1 | Frame-valid strobe to host |
| sdo_o | output | 1 | Serial data |
| busy_o | output | 1 | Conversion (and, in read-after-convert, transfer) in progress |

## Verification
The bench sweeps every combination of timing mode, divider, channel order and both inversions. Each frame is checked cycle by cycle against an arithmetic model of the clock, strobe and data lines. A wrong half-period count or a missing inter-channel gap shifts every following bit. A wrong channel order swaps the frame halves. A wrong inversion shows at idle as well as mid-frame. The bench also fires a start in the middle of a read-after-convert frame, which a design that accepts it would show as a busy line that stays high. It fires a second start while a read-during-convert frame is still shifting, which a design that restarts would show as a frame truncated back to its MSB. A stray done outside a conversion is followed by a frame that must still carry the earlier pair. A start right after reset must produce no frame at all.

// File: rtl/dual_rs_pkg.sv
package dual_rs_pkg;
  typedef enum logic {
    RD_AFTER  = 1'b0,
    RD_DURING = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rs_conv_tracker.sv
module rs_conv_tracker #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_ok_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] res_a_i,
  input  logic [DATA_W-1:0] res_b_i,
  output logic              converting_o,
  output logic              done_ok_o,
  output logic              have_pair_o,
  output logic [DATA_W-1:0] held_a_o,
  output logic [DATA_W-1:0] held_b_o
);
  logic conv_q;

  assign done_ok_o    = done_i & conv_q;
  assign converting_o = conv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q      <= 1'b0;
      have_pair_o <= 1'b0;
      held_a_o    <= '0;
      held_b_o    <= '0;
    end else begin
      if (start_ok_i) conv_q <= 1'b1;
      else if (done_ok_o) conv_q <= 1'b0;
      // both channels captured together once B is done
      if (done_ok_o) begin
        held_a_o    <= res_a_i;
        held_b_o    <= res_b_i;
        have_pair_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_half_timer.sv
module rs_half_timer #(
  parameter int TW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] lim_i,
  output logic          ev_o
);
  logic [TW-1:0] cnt_q;

  assign ev_o = run_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (run_i && !ev_o)  cnt_q <= cnt_q + 1'b1;
    else                      cnt_q <= '0;
  end
endmodule

// File: rtl/rs_frame_shifter.sv
module rs_frame_shifter #(
  parameter int DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [2*DATA_W-1:0] frame_i,
  input  logic                ev_i,
  output logic                active_o,
  output logic                sclk_o,
  output logic                gap_o,
  output logic                sdo_o
);
  localparam int FRAME_W = 2 * DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] SPLIT    = CNT_W'(DATA_W - 1);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   bit_q;

  assign sdo_o = sr_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      sclk_o   <= 1'b0;
      gap_o    <= 1'b0;
      bit_q    <= '0;
      sr_q     <= '0;
    end else if (load_i) begin
      active_o <= 1'b1;
      sclk_o   <= 1'b0;
      gap_o    <= 1'b0;
      bit_q    <= '0;
      sr_q     <= frame_i;
    end else if (active_o && ev_i) begin
      if (gap_o) begin
        gap_o <= 1'b0;
      end else if (!sclk_o) begin
        sclk_o <= 1'b1;
      end else begin
        // falling edge: advance data
        sclk_o <= 1'b0;
        if (bit_q == LAST_BIT) begin
          active_o <= 1'b0;
          sr_q     <= '0;
        end else begin
          bit_q <= bit_q + 1'b1;
          sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
          if (bit_q == SPLIT) gap_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dual_result_shifter.sv
module dual_result_shifter
  import dual_rs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_during_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic              a_first_i,
  input  logic              sclk_inv_i,
  input  logic              sync_inv_i,
  input  logic              conv_start_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] res_a_i,
  input  logic [DATA_W-1:0] res_b_i,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              sdo_o,
  output logic              busy_o
);
  localparam int FRAME_W = 2 * DATA_W;
  localparam int TW      = (2 ** DIV_W) - 1;

  rd_mode_e mode_w, mode_q;
  logic [TW-1:0] lim_w, lim_q;
  logic [TW:0]   span_w;
  logic start_ok, done_ok, converting, have_pair;
  logic load_after, load_during, load;
  logic active, sclk_raw, gap, ev;
  logic [DATA_W-1:0]  held_a, held_b, src_a, src_b;
  logic [FRAME_W-1:0] frame_w;

  assign mode_w = rd_during_i ? RD_DURING : RD_AFTER;
  assign busy_o = converting | (active & (mode_q == RD_AFTER));
  assign start_ok = conv_start_i & ~busy_o;

  assign load_after  = done_ok & (mode_w == RD_AFTER) & ~active;
  assign load_during = start_ok & (mode_w == RD_DURING) & have_pair & ~active;
  assign load        = load_after | load_during;

  assign src_a   = load_after ? res_a_i : held_a;
  assign src_b   = load_after ? res_b_i : held_b;
  assign frame_w = a_first_i ? {src_a, src_b} : {src_b, src_a};

  assign span_w = (TW + 1)'(1) << div_sel_i;
  assign lim_w  = (mode_w == RD_DURING) ? '0 : TW'(span_w - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RD_AFTER;
      lim_q  <= '0;
    end else if (load) begin
      mode_q <= mode_w;
      lim_q  <= lim_w;
    end
  end

  rs_conv_tracker #(.DATA_W(DATA_W)) i_conv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_ok_i  (start_ok),
    .done_i      (conv_done_i),
    .res_a_i     (res_a_i),
    .res_b_i     (res_b_i),
    .converting_o(converting),
    .done_ok_o   (done_ok),
    .have_pair_o (have_pair),
    .held_a_o    (held_a),
    .held_b_o    (held_b)
  );

  rs_half_timer #(.TW(TW)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (active),
    .lim_i (lim_q),
    .ev_o  (ev)
  );

  rs_frame_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .frame_i (frame_w),
    .ev_i    (ev),
    .active_o(active),
    .sclk_o  (sclk_raw),
    .gap_o   (gap),
    .sdo_o   (sdo_o)
  );

  assign sclk_o = sclk_raw ^ sclk_inv_i;
  assign sync_o = (active & ~gap) ^ sync_inv_i;
endmodule

// File: rtl/dual_rs_chk.sv
module dual_rs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic active,
  input logic sclk_raw,
  input logic gap,
  input logic load,
  input logic mode_during,
  input logic busy_o,
  input logic sdo_o
);
  // R1
  sdo_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_raw && $past(sclk_raw)) |-> $stable(sdo_o));
  // R3
  gap_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap |-> !sclk_raw);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (!sclk_raw && !sdo_o));
  // R6
  after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !mode_during) |-> busy_o);
  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> !active);
endmodule

bind dual_result_shifter dual_rs_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .active     (active),
  .sclk_raw   (sclk_raw),
  .gap        (gap),
  .load       (load),
  .mode_during(mode_q == dual_rs_pkg::RD_DURING),
  .busy_o     (busy_o),
  .sdo_o      (sdo_o)
);

// File: tb/test_dual_result_shifter.sv
module test_dual_result_shifter;
  localparam int DW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_during_i = 1'b0;
  logic [1:0] div_sel_i = '0;
  logic a_first_i = 1'b1;
  logic sclk_inv_i = 1'b0;
  logic sync_inv_i = 1'b0;
  logic conv_start_i = 1'b0;
  logic conv_done_i = 1'b0;
  logic [DW-1:0] res_a_i = '0;
  logic [DW-1:0] res_b_i = '0;
  logic sclk_o, sync_o, sdo_o, busy_o;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  logic [DW-1:0] held_a = '0;
  logic [DW-1:0] held_b = '0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  dual_result_shifter i_dual_result_shifter (.*);

  initial begin
    wait (cyc >= 190000);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] da(int i);
    return DW'(i * 40503 + 23117);
  endfunction
  function automatic logic [DW-1:0] db(int i);
    return DW'((i * 12345) ^ 16'hC3A5);
  endfunction

  // expected raw clock, strobe and data at cycle t after load, half-period h
  task automatic check_cycle(input int t, input int h, input logic [2*DW-1:0] fr);
    logic s, y, d;
    int k;
    if (t < 32 * h) begin
      k = t / (2 * h); s = (t % (2 * h)) >= h; y = 1'b1; d = fr[31-k];
    end else if (t < 33 * h) begin
      s = 1'b0; y = 1'b0; d = fr[15];
    end else if (t < 65 * h) begin
      k = 16 + (t - 33 * h) / (2 * h); s = ((t - 33 * h) % (2 * h)) >= h;
      y = 1'b1; d = fr[31-k];
    end else begin
      s = 1'b0; y = 1'b0; d = 1'b0;
    end
    chk("R1/R5/R4 sclk", sclk_o, s ^ sclk_inv_i);
    chk("R3/R4 sync", sync_o, y ^ sync_inv_i);
    chk("R1/R2 sdo", sdo_o, d);
  endtask

  task automatic run_during(input int idx, input logic af, input logic si, input logic yi,
                            input logic [1:0] dv);
    logic [2*DW-1:0] fr;
    logic [DW-1:0] na, nb;
    na = da(idx); nb = db(idx);
    rd_during_i = 1'b1; a_first_i = af; sclk_inv_i = si; sync_inv_i = yi; div_sel_i = dv;
    fr = af ? {held_a, held_b} : {held_b, held_a};
    conv_start_i = 1'b1;
    @(negedge clk_i);
    conv_start_i = 1'b0;
    for (int t = 0; t <= 65; t++) begin
      check_cycle(t, 1, fr);
      chk("R7 busy", busy_o, (t <= 10) || (t > 20));
      conv_done_i  = (t == 10);
      conv_start_i = (t == 20); // R9: start mid-frame must not reload
      res_a_i = na; res_b_i = nb;
      @(negedge clk_i);
    end
    conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    chk("R7 busy after done", busy_o, 1'b0);
    held_a = na; held_b = nb;
  endtask

  task automatic run_after(input int idx, input logic af, input logic si, input logic yi,
                           input logic [1:0] dv);
    logic [2*DW-1:0] fr;
    int h;
    h = 1 << dv;
    rd_during_i = 1'b0; a_first_i = af; sclk_inv_i = si; sync_inv_i = yi; div_sel_i = dv;
    res_a_i = da(idx); res_b_i = db(idx);
    fr = af ? {da(idx), db(idx)} : {db(idx), da(idx)};
    conv_start_i = 1'b1;
    @(negedge clk_i);
    conv_start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R6 busy in conversion", busy_o, 1'b1);
    conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    for (int t = 0; t <= 65 * h; t++) begin
      check_cycle(t, h, fr);
      chk("R6 busy", busy_o, t < 65 * h);
      conv_start_i = (t == 5); // R8: ignored while busy
      @(negedge clk_i);
    end
    held_a = da(idx); held_b = db(idx);
  endtask

  initial begin
    int idx;
    repeat (3) @(negedge clk_i);
    chk("R10 busy in reset", busy_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 sclk idle", sclk_o, 1'b0);
    chk("R10 sync idle", sync_o, 1'b0);
    chk("R10 sdo idle", sdo_o, 1'b0);
    chk("R10 busy idle", busy_o, 1'b0);
    sclk_inv_i = 1'b1; sync_inv_i = 1'b1;
    #1;
    chk("R4 sclk idle inverted", sclk_o, 1'b1);
    chk("R4 sync idle inverted", sync_o, 1'b1);
    sclk_inv_i = 1'b0; sync_inv_i = 1'b0;

    // R9: no pair captured yet, so no frame
    rd_during_i = 1'b1;
    conv_start_i = 1'b1;
    @(negedge clk_i);
    conv_start_i = 1'b0;
    for (int t = 0; t < 40; t++) begin
      chk("R9 no frame sclk", sclk_o, 1'b0);
      chk("R9 no frame sync", sync_o, 1'b0);
      chk("R7 busy converting", busy_o, 1'b1);
      @(negedge clk_i);
    end
    res_a_i = 16'h8001; res_b_i = 16'h7FFE;
    conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    chk("R7 busy falls", busy_o, 1'b0);
    held_a = 16'h8001; held_b = 16'h7FFE;

    // R8: stray done outside a conversion
    res_a_i = 16'hDEAD; res_b_i = 16'hBEEF;
    conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    for (int t = 0; t < 10; t++) begin
      chk("R8 stray done busy", busy_o, 1'b0);
      chk("R8 stray done sclk", sclk_o, 1'b0);
      @(negedge clk_i);
    end

    idx = 0;
    for (int m = 1; m >= 0; m--)
      for (int dv = 0; dv < 4; dv++)
        for (int af = 0; af < 2; af++)
          for (int si = 0; si < 2; si++)
            for (int yi = 0; yi < 2; yi++) begin
              if (m == 1) run_during(idx, af[0], si[0], yi[0], dv[1:0]);
              else        run_after(idx, af[0], si[0], yi[0], dv[1:0]);
              idx++;
            end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule